// File: doc/BRIEF.md
# Authenticated Load Sequencer

This block carries out one pointer-authenticated 64-bit load over several clock cycles. A caller presents a 32-bit instruction word with a one-cycle `start` pulse. The block decodes the word and raises `illegal` if the word does not have this load's fixed bit pattern. For an accepted word it reads the base from the register file, or from the stack pointer input when the base index is 31. It then hands that pointer to an external authenticator with a modifier of zero and the key the word selects, and waits for a pass or fail answer together with the stripped address.

On a pass the block adds the scaled signed offset to the stripped address and issues a single 64-bit memory read. It writes the returned data to the destination register. When the word requests pre-indexing it also writes the updated address back to the base. The authenticator, the memory system and fault handling are outside the block; each is reached through a valid/ready request and a response strobe.

Top module: `authld_seq`

## Requirements
- R1: A `start` word is accepted only when bits 31..24 are 8'b11111000, bit 21 is 1 and bit 10 is 1. Any other word gives a one-cycle `illegal` pulse in the cycle after `start`, and no authenticator request follows.
- R2: Each authenticator request drives `auth_mod` to zero and sets `auth_key_b` to bit 23 of the word (0 = key A, 1 = key B).
- R3: The base index is bits 9..5 and the destination index is bits 4..0. For a base index of 31, `auth_ptr` is `sp_in`; otherwise it is the register file entry at that index.
- R4: The memory address is the authenticator's returned address plus the offset. The offset is the 10-bit value {bit 22, bits 20..12}, sign-extended and multiplied by 8, so it ranges from -4096 to 4088.
- R5: An authentication fail gives a one-cycle `auth_fault` pulse, no memory read and no register write, and the block returns to idle.
- R6: With a base index of 31 and `sp_in` not 16-byte aligned, a pass gives a one-cycle `align_fault` pulse, no memory read and no register write.
- R7: The read data is written to the destination index through `rd_we`/`rd_idx`/`rd_data`, followed one cycle later by a one-cycle `done` pulse.
- R8: With bit 11 set, the returned address plus offset is written to the base in the same cycle as the destination write: through `wb_we` for a general register, or `sp_we` for the stack pointer. With bit 11 clear, the base is not written.
- R9: With bit 11 set and the base index equal to the destination index (not 31), the load and the destination write still happen, but no base write occurs.
- R10: `mem_tagchk` is 1 when bit 11 is set or the base index is not 31, and 0 otherwise.
- R11: `auth_valid` and `mem_valid` each stay high, with stable payload, until their ready is seen. `busy` is high from the cycle after an accepted `start` until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction word is valid this cycle (honoured while idle) |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Sequence in progress |
| illegal | output | 1 | Word was not this load |
| done | output | 1 | Load completed |
| auth_fault | output | 1 | Authentication failed |
| align_fault | output | 1 | Stack pointer base misaligned |
| rf_raddr | output | 5 | Register file read index (base) |
| rf_rdata | input | 64 | Register file read data |
| sp_in | input | 64 | Current stack pointer |
| auth_valid | output | 1 | Authenticate request valid |
| auth_ready | input | 1 | Authenticator accepts request |
| auth_ptr | output | 64 | Pointer to authenticate |
| auth_mod | output | 64 | Modifier (always zero) |
| auth_key_b | output | 1 | Key select, 1 = key B |
| auth_rsp_valid | input | 1 | Authenticator result strobe |
| auth_pass | input | 1 | Authentication passed |
| auth_addr | input | 64 | Stripped address |
| mem_valid | output | 1 | Memory read request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_addr | output | 64 | Read byte address |
| mem_tagchk | output | 1 | Access is tag checked |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 64 | Read data |
| rd_we | output | 1 | Destination register write |
| rd_idx | output | 5 | Destination index |
| rd_data | output | 64 | Destination data |
| wb_we | output | 1 | Base general-register writeback |
| wb_idx | output | 5 | Base index |
| wb_data | output | 64 | Writeback address |
| sp_we | output | 1 | Stack pointer writeback |
| sp_data | output | 64 | New stack pointer |

## Verification
The destination data write and the base writeback happen in the same cycle, and this is where ordering errors would show. The bench records the cycle of each strobe for pre-indexed loads that use a general-register base and a stack pointer base, and requires the two cycles to be equal, with each address and data value computed from the word. The overlap case, with a shared base and destination index, is run in the same way. There the destination write must still appear while both writeback strobes stay low for the whole run.

// File: rtl/authld_pkg.sv
package authld_pkg;
  parameter int unsigned XLEN   = 64;
  parameter int unsigned REG_AW = 5;
  localparam logic [REG_AW-1:0] SP_IDX = '1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_AUTH_REQ, ST_AUTH_WAIT, ST_MEM_REQ, ST_MEM_WAIT, ST_WRITE, ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic              key_b;
    logic              wback;    // writeback after overlap suppression
    logic              use_sp;
    logic              tagchk;
    logic [REG_AW-1:0] base_idx;
    logic [REG_AW-1:0] dst_idx;
    logic [XLEN-1:0]   offset;
  } op_fields_t;
endpackage

// File: rtl/authld_decode.sv
module authld_decode
  import authld_pkg::*;
(
  input  logic [31:0] word,
  output logic        is_op,
  output op_fields_t  fields
);
  localparam int unsigned SHIFT = 3;
  localparam int unsigned EXT   = XLEN - 10 - SHIFT;

  logic              w_bit;
  logic [REG_AW-1:0] rn, rt;

  assign is_op = (word[31:24] == 8'hF8) && word[21] && word[10];
  assign w_bit = word[11];
  assign rn    = word[9:5];
  assign rt    = word[4:0];

  always_comb begin
    fields.key_b    = word[23];
    fields.use_sp   = (rn == SP_IDX);
    fields.tagchk   = w_bit || (rn != SP_IDX);
    fields.wback    = w_bit && !((rn == rt) && (rn != SP_IDX));
    fields.base_idx = rn;
    fields.dst_idx  = rt;
    fields.offset   = {{EXT{word[22]}}, word[22], word[20:12], {SHIFT{1'b0}}};
  end
endmodule

// File: rtl/authld_agen.sv
module authld_agen
  import authld_pkg::*;
#(
  parameter int unsigned ALIGN_LG2 = 4
) (
  input  logic [XLEN-1:0] base,
  input  logic            use_sp,
  input  logic [XLEN-1:0] stripped,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] eff_addr,
  output logic            misaligned
);
  assign eff_addr   = stripped + offset;
  assign misaligned = use_sp && (|base[ALIGN_LG2-1:0]);
endmodule

// File: rtl/authld_seq.sv
module authld_seq
  import authld_pkg::*;
#(
  parameter int unsigned ALIGN_LG2 = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [31:0]            instr,
  output logic                   busy,
  output logic                   illegal,
  output logic                   done,
  output logic                   auth_fault,
  output logic                   align_fault,
  output logic [REG_AW-1:0]      rf_raddr,
  input  logic [XLEN-1:0]        rf_rdata,
  input  logic [XLEN-1:0]        sp_in,
  output logic                   auth_valid,
  input  logic                   auth_ready,
  output logic [XLEN-1:0]        auth_ptr,
  output logic [XLEN-1:0]        auth_mod,
  output logic                   auth_key_b,
  input  logic                   auth_rsp_valid,
  input  logic                   auth_pass,
  input  logic [XLEN-1:0]        auth_addr,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic [XLEN-1:0]        mem_addr,
  output logic                   mem_tagchk,
  input  logic                   mem_rvalid,
  input  logic [XLEN-1:0]        mem_rdata,
  output logic                   rd_we,
  output logic [REG_AW-1:0]      rd_idx,
  output logic [XLEN-1:0]        rd_data,
  output logic                   wb_we,
  output logic [REG_AW-1:0]      wb_idx,
  output logic [XLEN-1:0]        wb_data,
  output logic                   sp_we,
  output logic [XLEN-1:0]        sp_data
);
  seq_state_t      state;
  op_fields_t      dec_now, op_q;
  logic            dec_ok;
  logic [XLEN-1:0] base_q, eff_q, data_q, eff_next;
  logic            misaligned;
  logic            auth_v_q, mem_v_q;
  logic            ill_q, afault_q, alfault_q;

  authld_decode u_dec (
    .word   (instr),
    .is_op  (dec_ok),
    .fields (dec_now)
  );

  authld_agen #(.ALIGN_LG2(ALIGN_LG2)) u_agen (
    .base       (base_q),
    .use_sp     (op_q.use_sp),
    .stripped   (auth_addr),
    .offset     (op_q.offset),
    .eff_addr   (eff_next),
    .misaligned (misaligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= '0;
      base_q    <= '0;
      eff_q     <= '0;
      data_q    <= '0;
      auth_v_q  <= 1'b0;
      mem_v_q   <= 1'b0;
      ill_q     <= 1'b0;
      afault_q  <= 1'b0;
      alfault_q <= 1'b0;
    end else begin
      ill_q     <= 1'b0;
      afault_q  <= 1'b0;
      alfault_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (dec_ok) begin
              op_q  <= dec_now;
              state <= ST_AUTH_REQ;
            end else begin
              ill_q <= 1'b1;
            end
          end
        end
        ST_AUTH_REQ: begin
          base_q   <= op_q.use_sp ? sp_in : rf_rdata;
          auth_v_q <= 1'b1;
          state    <= ST_AUTH_WAIT;
        end
        ST_AUTH_WAIT: begin
          if (auth_v_q) begin
            if (auth_ready) auth_v_q <= 1'b0;
          end else if (auth_rsp_valid) begin
            if (!auth_pass) begin
              afault_q <= 1'b1;
              state    <= ST_IDLE;
            end else if (misaligned) begin
              alfault_q <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              eff_q   <= eff_next;
              mem_v_q <= 1'b1;
              state   <= ST_MEM_REQ;
            end
          end
        end
        ST_MEM_REQ: begin
          if (mem_ready) begin
            mem_v_q <= 1'b0;
            state   <= ST_MEM_WAIT;
          end
        end
        ST_MEM_WAIT: begin
          if (mem_rvalid) begin
            data_q <= mem_rdata;
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign illegal     = ill_q;
  assign auth_fault  = afault_q;
  assign align_fault = alfault_q;
  assign done        = (state == ST_DONE);

  assign rf_raddr    = op_q.base_idx;
  assign auth_valid  = auth_v_q;
  assign auth_ptr    = base_q;
  assign auth_mod    = '0;
  assign auth_key_b  = op_q.key_b;

  assign mem_valid   = mem_v_q;
  assign mem_addr    = eff_q;
  assign mem_tagchk  = op_q.tagchk;

  assign rd_we       = (state == ST_WRITE);
  assign rd_idx      = op_q.dst_idx;
  assign rd_data     = data_q;
  assign wb_we       = (state == ST_WRITE) && op_q.wback && !op_q.use_sp;
  assign wb_idx      = op_q.base_idx;
  assign wb_data     = eff_q;
  assign sp_we       = (state == ST_WRITE) && op_q.wback && op_q.use_sp;
  assign sp_data     = eff_q;
endmodule

// File: rtl/authld_seq_chk.sv
module authld_seq_chk
  import authld_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            auth_fault,
  input logic            align_fault,
  input logic            auth_valid,
  input logic            auth_ready,
  input logic [XLEN-1:0] auth_ptr,
  input logic [XLEN-1:0] auth_mod,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [XLEN-1:0] mem_addr,
  input logic            rd_we,
  input logic            wb_we,
  input logic            sp_we
);
  a_r2_zero_modifier: assert property (@(posedge clk) disable iff (rst)
    auth_valid |-> (auth_mod == '0));

  a_r11_auth_hold: assert property (@(posedge clk) disable iff (rst)
    (auth_valid && !auth_ready) |=> (auth_valid && $stable(auth_ptr)));

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  a_r11_busy_cover: assert property (@(posedge clk) disable iff (rst)
    (auth_valid || mem_valid || rd_we) |-> busy);

  a_r5_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    (auth_fault || align_fault) |-> !(rd_we || wb_we || sp_we || mem_valid));

  a_r8_wb_with_dest: assert property (@(posedge clk) disable iff (rst)
    (wb_we || sp_we) |-> rd_we);

  a_r8_one_base_port: assert property (@(posedge clk) disable iff (rst)
    $countones({wb_we, sp_we}) <= 1);
endmodule

bind authld_seq authld_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .auth_fault  (auth_fault),
  .align_fault (align_fault),
  .auth_valid  (auth_valid),
  .auth_ready  (auth_ready),
  .auth_ptr    (auth_ptr),
  .auth_mod    (auth_mod),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .rd_we       (rd_we),
  .wb_we       (wb_we),
  .sp_we       (sp_we)
);

// File: tb/tb_authld_seq.sv
`timescale 1ns/1ps
module tb_authld_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        busy, illegal, done, auth_fault, align_fault;
  logic [4:0]  rf_raddr;
  logic [63:0] rf_rdata;
  logic [63:0] sp_in = '0;
  logic        auth_valid, auth_key_b;
  logic        auth_ready = 1'b0, auth_rsp_valid = 1'b0, auth_pass = 1'b0;
  logic [63:0] auth_ptr, auth_mod;
  logic [63:0] auth_addr = '0;
  logic        mem_valid, mem_tagchk;
  logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [63:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        rd_we, wb_we, sp_we;
  logic [4:0]  rd_idx, wb_idx;
  logic [63:0] rd_data, wb_data, sp_data;

  logic [63:0] regs [32];
  assign rf_rdata = regs[rf_raddr];

  always #2.5 clk = ~clk;

  authld_seq dut (.*);

  int vectors = 0;
  int misses  = 0;

  // observations of one run
  int          n_auth, n_mem, n_rd, n_wb, n_sp, rd_cyc, wb_cyc, sp_cyc;
  logic        f_ill, f_auth, f_align, f_done, o_key;
  logic [63:0] o_ptr, o_mod, o_maddr, o_rdd, o_wbd, o_spd;
  logic [4:0]  o_rdi, o_wbi;
  logic        o_tag;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic m, input logic [9:0] simm,
                                     input logic w, input logic [4:0] rn, input logic [4:0] rt);
    return {8'hF8, m, simm[9], 1'b1, simm[8:0], w, 1'b1, rn, rt};
  endfunction

  function automatic logic [63:0] offs(input logic [9:0] simm);
    return {{54{simm[9]}}, simm} << 3;
  endfunction

  task automatic run_op(input logic [31:0] w, input logic pass, input logic [63:0] aaddr,
                        input logic [63:0] rdat, input int dly);
    int ast = 0, mst = 0, acnt = 0, mcnt = 0;
    n_auth = 0; n_mem = 0; n_rd = 0; n_wb = 0; n_sp = 0;
    rd_cyc = -1; wb_cyc = -2; sp_cyc = -3;
    f_ill = 0; f_auth = 0; f_align = 0; f_done = 0;
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (illegal) f_ill = 1;
      if (auth_fault) f_auth = 1;
      if (align_fault) f_align = 1;
      if (done) f_done = 1;
      if (rd_we) begin n_rd++; rd_cyc = c; o_rdi = rd_idx; o_rdd = rd_data; end
      if (wb_we) begin n_wb++; wb_cyc = c; o_wbi = wb_idx; o_wbd = wb_data; end
      if (sp_we) begin n_sp++; sp_cyc = c; o_spd = sp_data; end
      // authenticator responder
      if (ast == 1) begin
        auth_ready = 0; auth_rsp_valid = 1; auth_pass = pass; auth_addr = aaddr; ast = 2;
      end else if (ast == 2) begin
        auth_rsp_valid = 0; ast = 3;
      end else if (ast == 0 && auth_valid) begin
        if (acnt == 0) begin n_auth++; o_ptr = auth_ptr; o_mod = auth_mod; o_key = auth_key_b; end
        if (acnt >= dly) begin auth_ready = 1; ast = 1; end
        acnt++;
      end
      // memory responder
      if (mst == 1) begin
        mem_ready = 0; mem_rvalid = 1; mem_rdata = rdat; mst = 2;
      end else if (mst == 2) begin
        mem_rvalid = 0; mst = 3;
      end else if (mst == 0 && mem_valid) begin
        if (mcnt == 0) begin n_mem++; o_maddr = mem_addr; o_tag = mem_tagchk; end
        if (mcnt >= dly) begin mem_ready = 1; mst = 1; end
        mcnt++;
      end
      @(negedge clk);
    end
    chk("R11 idle after run", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R11 reset busy", {63'd0, busy}, 64'd0);
    chk("R11 reset auth_valid", {63'd0, auth_valid}, 64'd0);
    chk("R11 reset mem_valid", {63'd0, mem_valid}, 64'd0);
    chk("R7 reset rd_we", {61'd0, rd_we, wb_we, sp_we}, 64'd0);
  endtask

  task automatic t_illegal;
    run_op(mk(0, 10'd1, 0, 5'd3, 5'd5) & ~32'h0000_0400, 1, 64'h100, 64'h1, 0);
    chk("R1 bit10 clear flagged", {63'd0, f_ill}, 64'd1);
    chk("R1 bit10 clear no auth", 64'(n_auth), 64'd0);
    run_op(mk(0, 10'd1, 0, 5'd3, 5'd5) & ~32'h0020_0000, 1, 64'h100, 64'h1, 0);
    chk("R1 bit21 clear flagged", {63'd0, f_ill}, 64'd1);
    chk("R1 bit21 clear no auth", 64'(n_auth), 64'd0);
  endtask

  task automatic t_basic_keya;
    logic [63:0] a = 64'h0000_0000_1234_5000;
    run_op(mk(0, 10'd5, 0, 5'd3, 5'd5), 1, a, 64'hDEAD_BEEF_0000_0001, 0);
    chk("R1 legal not flagged", {63'd0, f_ill}, 64'd0);
    chk("R3 ptr from register", o_ptr, regs[3]);
    chk("R2 key A", {63'd0, o_key}, 64'd0);
    chk("R2 modifier zero", o_mod, 64'd0);
    chk("R4 address positive", o_maddr, a + 64'd40);
    chk("R10 tag gp base", {63'd0, o_tag}, 64'd1);
    chk("R7 dest written once", 64'(n_rd), 64'd1);
    chk("R7 dest index", {59'd0, o_rdi}, 64'd5);
    chk("R7 dest data", o_rdd, 64'hDEAD_BEEF_0000_0001);
    chk("R7 done seen", {63'd0, f_done}, 64'd1);
    chk("R8 no writeback when W clear", 64'(n_wb + n_sp), 64'd0);
  endtask

  task automatic t_keyb_wb;
    logic [63:0] a = 64'h0000_0000_8000_2000;
    run_op(mk(1, 10'h200, 1, 5'd7, 5'd2), 1, a, 64'h0123_4567_89AB_CDEF, 2);
    chk("R2 key B", {63'd0, o_key}, 64'd1);
    chk("R4 address -4096", o_maddr, a - 64'd4096);
    chk("R8 base written", 64'(n_wb), 64'd1);
    chk("R8 base index", {59'd0, o_wbi}, 64'd7);
    chk("R8 base data stripped+offset", o_wbd, a - 64'd4096);
    chk("R8 same cycle as dest", 64'(wb_cyc), 64'(rd_cyc));
    chk("R7 dest data", o_rdd, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_sp_wb;
    logic [63:0] a = 64'h0000_7FFF_0000_1000;
    sp_in = 64'h5A00_7FFF_0000_1000;
    run_op(mk(0, 10'd511, 1, 5'd31, 5'd9), 1, a, 64'h55, 3);
    chk("R3 ptr from stack pointer", o_ptr, sp_in);
    chk("R4 address +4088", o_maddr, a + 64'd4088);
    chk("R10 tag sp with W", {63'd0, o_tag}, 64'd1);
    chk("R8 sp written", 64'(n_sp), 64'd1);
    chk("R8 sp data", o_spd, a + 64'd4088);
    chk("R8 sp same cycle as dest", 64'(sp_cyc), 64'(rd_cyc));
    chk("R8 no gp base write", 64'(n_wb), 64'd0);
  endtask

  task automatic t_sp_nowb;
    sp_in = 64'h0000_0000_0000_4000;
    run_op(mk(0, 10'h3FF, 0, 5'd31, 5'd1), 1, 64'h4000, 64'h77, 1);
    chk("R10 tag sp without W", {63'd0, o_tag}, 64'd0);
    chk("R4 address -8", o_maddr, 64'h3FF8);
    chk("R8 sp untouched", 64'(n_sp + n_wb), 64'd0);
  endtask

  task automatic t_sp_misaligned;
    sp_in = 64'h0000_0000_0000_5008;
    run_op(mk(0, 10'd2, 1, 5'd31, 5'd4), 1, 64'h5008, 64'h99, 0);
    chk("R6 align fault", {63'd0, f_align}, 64'd1);
    chk("R6 no memory read", 64'(n_mem), 64'd0);
    chk("R6 no writes", 64'(n_rd + n_wb + n_sp), 64'd0);
  endtask

  task automatic t_auth_fail;
    run_op(mk(1, 10'd3, 1, 5'd6, 5'd8), 0, 64'h9000, 64'h11, 1);
    chk("R5 auth fault", {63'd0, f_auth}, 64'd1);
    chk("R5 no memory read", 64'(n_mem), 64'd0);
    chk("R5 no writes", 64'(n_rd + n_wb + n_sp), 64'd0);
    chk("R5 no done", {63'd0, f_done}, 64'd0);
  endtask

  task automatic t_overlap;
    run_op(mk(0, 10'd1, 1, 5'd4, 5'd4), 1, 64'hA000, 64'hCAFE, 0);
    chk("R9 load performed", 64'(n_mem), 64'd1);
    chk("R9 dest written", 64'(n_rd), 64'd1);
    chk("R9 dest data", o_rdd, 64'hCAFE);
    chk("R9 writeback suppressed", 64'(n_wb + n_sp), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'h00C0_0000_0000_0000 | (64'(i) << 12);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_illegal();
    t_basic_keya();
    t_keyb_wb();
    t_sp_wb();
    t_sp_nowb();
    t_sp_misaligned();
    t_auth_fail();
    t_overlap();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule